// File: doc/BRIEF.md
# Start/Ready Handshake Monitor

This block watches a one-bit request line (`start`) and a one-bit response line (`ready`) on a single clock and reports protocol violations in hardware. A request opens when `start` is sampled high while nothing is pending. The response must then be sampled between 1 and `LIMIT` cycles later, and `start` must stay low until it arrives. Any latency in that range is legal.

Four sticky error flags cover the illegal cases:
- a repeated start while a request is pending,
- a missing response within the window,
- start and ready high in the same cycle,
- a ready that no request asked for.

When a handshake completes cleanly, the block gives a one-cycle `done` pulse and latches the measured latency. With `LIMIT` set to 0 the window has no bound. In that mode the timeout check is off, and `busy` shows a request that is still open.

The monitor keeps checking after an error. The `clr` input or reset clears the flags.

Top module: `hsk_watch`

## Requirements
- R1: After reset, `busy`, `done`, `lat` and all four error flags are 0.
- R2: `start` sampled high while idle opens a request. `busy` reads 1 from the next cycle until the request ends by `ready` or by timeout.
- R3: If `ready` is sampled k cycles after the opening `start` (1 ≤ k ≤ `LIMIT`), and `start` was low in every cycle from the one after the opening `start` through the `ready` cycle, then `done` is high for exactly the next cycle and `lat` holds k from then on.
- R4: `start` sampled high while a request is pending sets `err_restart` in the next cycle. The request stays open. When `ready` later ends it, no `done` pulse is produced.
- R5: `start` and `ready` sampled high in the same cycle set `err_overlap` in the next cycle. When this happens while idle, the `start` still opens a request.
- R6: `ready` sampled high while idle and without `start` sets `err_unsol` in the next cycle.
- R7: With `LIMIT` > 0, if no `ready` arrives by the cycle `LIMIT` cycles after the opening `start`, then `err_timeout` is 1 and `busy` is 0 in the cycle after that.
- R8: With `LIMIT` = 0, `err_timeout` never rises and `busy` stays 1 until `ready` arrives.
- R9: Error flags hold until reset or until `clr` is sampled high. If `clr` and a new error fall in the same cycle, that flag is set.
- R10: After any error, later clean handshakes still produce `done` with the correct latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request line being monitored |
| ready | input | 1 | Response line being monitored |
| clr | input | 1 | Clears the sticky error flags |
| busy | output | 1 | A request is pending |
| done | output | 1 | One-cycle pulse after a clean handshake |
| lat | output | CNT_W | Latency of the last clean handshake, in cycles |
| err_restart | output | 1 | Start repeated while pending |
| err_timeout | output | 1 | No ready within `LIMIT` cycles |
| err_overlap | output | 1 | Start and ready in the same cycle |
| err_unsol | output | 1 | Ready with no pending request |

## Verification
A clearing pulse on `clr` can arrive in the same cycle as a new violation. The bench raises `err_unsol`, then drives a stray `ready` together with `clr`, and expects the flag to remain 1. A following `clr` alone must drop it to 0. A second pair of events is also checked: `start` and `ready` together while a request is pending. The bench expects both `err_overlap` and `err_restart`, and the scoreboard must see no `done` pulse.

// File: rtl/hsk_watch_pkg.sv
package hsk_watch_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PEND = 1'b1
  } hsk_state_e;

  localparam int ERR_N       = 4;
  localparam int ERR_RESTART = 0;
  localparam int ERR_TIMEOUT = 1;
  localparam int ERR_OVERLAP = 2;
  localparam int ERR_UNSOL   = 3;
endpackage

// File: rtl/hsk_lat_ctr.sv
module hsk_lat_ctr #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (run && (cnt_q != CNT_MAX));
    cnt_d  = load ? CNT_W'(1) : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/hsk_err_flags.sv
module hsk_err_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q, f_d, f_en;
    always_comb begin
      f_en = set[i] || clr;
      f_d  = set[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    f_q <= 1'b0;
      else if (f_en) f_q <= f_d;
    end
    assign flags[i] = f_q;
  end
endmodule

// File: rtl/hsk_watch.sv
module hsk_watch
  import hsk_watch_pkg::*;
#(
  parameter int LIMIT = 1000,
  parameter int CNT_W = (LIMIT == 0) ? 32 : $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ready,
  input  logic             clr,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] lat,
  output logic             err_restart,
  output logic             err_timeout,
  output logic             err_overlap,
  output logic             err_unsol
);
  localparam bit               BOUNDED = (LIMIT != 0);
  localparam logic [CNT_W-1:0] LIM_C   = CNT_W'(LIMIT);

  hsk_state_e       st_q, st_d;
  logic             taint_q, taint_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] lat_q;
  logic             lat_en;
  logic [CNT_W-1:0] cnt;
  logic             idle, pend, launch, tmo;
  logic [ERR_N-1:0] err_set, err_flags;

  hsk_lat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (launch),
    .run   (pend),
    .cnt   (cnt)
  );

  always_comb begin
    idle   = (st_q == ST_IDLE);
    pend   = (st_q == ST_PEND);
    launch = idle && start;
    tmo    = BOUNDED && pend && !ready && (cnt == LIM_C);

    err_set              = '0;
    err_set[ERR_RESTART] = pend && start;
    err_set[ERR_TIMEOUT] = tmo;
    err_set[ERR_OVERLAP] = start && ready;
    err_set[ERR_UNSOL]   = idle && ready && !start;

    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_PEND;
      ST_PEND: if (ready || tmo) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase

    taint_d = taint_q;
    if (launch)              taint_d = 1'b0;
    else if (pend && start)  taint_d = 1'b1;

    done_d = pend && ready && !start && !taint_q;
    lat_en = done_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      taint_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      taint_q <= taint_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= cnt;
  end

  hsk_err_flags #(.N(ERR_N)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .set   (err_set),
    .flags (err_flags)
  );

  assign busy        = pend;
  assign done        = done_q;
  assign lat         = lat_q;
  assign err_restart = err_flags[ERR_RESTART];
  assign err_timeout = err_flags[ERR_TIMEOUT];
  assign err_overlap = err_flags[ERR_OVERLAP];
  assign err_unsol   = err_flags[ERR_UNSOL];
endmodule

// File: rtl/hsk_watch_chk.sv
module hsk_watch_chk #(
  parameter int LIMIT = 1000,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             ready,
  input logic             clr,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] lat,
  input logic             err_restart,
  input logic             err_timeout,
  input logic             err_overlap,
  input logic             err_unsol
);
  a_r2_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r3_lat_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((lat != '0) && ((LIMIT == 0) || (32'(lat) <= LIMIT))));

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> err_restart);

  a_r5_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> err_overlap);

  a_r6_unsol: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ready && !start) |=> err_unsol);

  a_r8_no_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (LIMIT == 0) |-> !err_timeout);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_restart && !clr) |=> err_restart);

  a_r9_sticky_unsol: assert property (@(posedge clk) disable iff (!rst_n)
    (err_unsol && !clr) |=> err_unsol);
endmodule

bind hsk_watch hsk_watch_chk #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .ready       (ready),
  .clr         (clr),
  .busy        (busy),
  .done        (done),
  .lat         (lat),
  .err_restart (err_restart),
  .err_timeout (err_timeout),
  .err_overlap (err_overlap),
  .err_unsol   (err_unsol)
);

// File: tb/hsk_watch_tb.sv
module hsk_watch_tb;
  localparam int LIM = 1000;
  localparam int WB  = $clog2(LIM + 1);

  logic clk = 1'b0;
  logic rst_n, start, ready, clr;
  logic busy, done, e_rs, e_to, e_ov, e_un;
  logic [WB-1:0] lat;
  logic u_busy, u_done, u_rs, u_to, u_ov, u_un;
  logic [31:0] u_lat;

  int n_chk = 0, n_bad = 0;
  int q_b[$];
  int q_u[$];

  always #5 clk = ~clk;

  hsk_watch #(.LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .clr(clr),
    .busy(busy), .done(done), .lat(lat), .err_restart(e_rs),
    .err_timeout(e_to), .err_overlap(e_ov), .err_unsol(e_un));

  hsk_watch #(.LIMIT(0)) u_unb (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .clr(clr),
    .busy(u_busy), .done(u_done), .lat(u_lat), .err_restart(u_rs),
    .err_timeout(u_to), .err_overlap(u_ov), .err_unsol(u_un));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic r, logic c);
    start = s; ready = r; clr = c;
    @(negedge clk);
  endtask

  task automatic hs(int k);
    cyc(1, 0, 0);
    for (int i = 1; i < k; i++) cyc(0, 0, 0);
    q_b.push_back(k);
    q_u.push_back(k);
    cyc(0, 1, 0);
    cyc(0, 0, 0);
  endtask

  // scoreboard monitors (R3, R10)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      if (q_b.size() == 0) chk("R3 unexpected done (bounded)", 1, 0);
      else chk("R3 latency (bounded)", int'(lat), q_b.pop_front());
    end
    if (rst_n === 1'b1 && u_done === 1'b1) begin
      if (q_u.size() == 0) chk("R3 unexpected done (unbounded)", 1, 0);
      else chk("R3 latency (unbounded)", int'(u_lat), q_u.pop_front());
    end
  end

  initial begin
    #2_000_000;
    chk("watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; ready = 0; clr = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset lat", int'(lat), 0);
    chk("R1 reset flags", int'({e_rs, e_to, e_ov, e_un}), 0);
    rst_n = 1'b1;
    cyc(0, 0, 0);

    // R2: open a request
    cyc(1, 0, 0);
    chk("R2 busy after start", busy, 1);
    cyc(0, 0, 0);
    chk("R2 busy while pending", busy, 1);
    q_b.push_back(2); q_u.push_back(2);
    cyc(0, 1, 0);
    chk("R2 busy drops after ready", busy, 0);
    chk("R3 done pulse", done, 1);
    cyc(0, 0, 0);
    chk("R3 done one cycle", done, 0);

    // R3: latency extremes and middle
    hs(1);
    hs(37);
    hs(LIM);
    chk("R7 no timeout at limit", e_to, 0);
    chk("R3 lat held", int'(lat), LIM);

    // R4: restart while pending
    cyc(1, 0, 0);
    cyc(0, 0, 0);
    cyc(1, 0, 0);
    chk("R4 err_restart", e_rs, 1);
    chk("R4 still pending", busy, 1);
    cyc(0, 1, 0);
    chk("R4 ready ends request", busy, 0);
    cyc(0, 0, 0);

    // R10: clean handshake after error
    hs(5);
    chk("R9 restart flag sticky", e_rs, 1);
    cyc(0, 0, 1);
    chk("R9 clr clears restart", e_rs, 0);

    // R5: overlap while idle opens a clean request
    cyc(1, 1, 0);
    chk("R5 err_overlap idle", e_ov, 1);
    chk("R5 overlap opens request", busy, 1);
    chk("R6 no unsol on overlap", e_un, 0);
    q_b.push_back(3); q_u.push_back(3);
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    cyc(0, 1, 0);
    cyc(0, 0, 1);
    chk("R9 clr clears overlap", e_ov, 0);

    // R5 + R4: overlap while pending, no done expected
    cyc(1, 0, 0);
    cyc(0, 0, 0);
    cyc(1, 1, 0);
    chk("R5 err_overlap pending", e_ov, 1);
    chk("R4 err_restart on overlap", e_rs, 1);
    chk("R4 request ended", busy, 0);
    cyc(0, 0, 1);

    // R6 and R9 clear/set collision
    cyc(0, 1, 0);
    chk("R6 err_unsol", e_un, 1);
    cyc(0, 1, 1);
    chk("R9 set wins over clr", e_un, 1);
    cyc(0, 0, 1);
    chk("R9 clr clears unsol", e_un, 0);

    // R7 / R8: timeout versus unbounded
    cyc(1, 0, 0);
    for (int i = 1; i < LIM; i++) cyc(0, 0, 0);
    chk("R7 no timeout before limit", e_to, 0);
    cyc(0, 0, 0);
    chk("R7 err_timeout", e_to, 1);
    chk("R7 busy low after timeout", busy, 0);
    chk("R8 unbounded busy", u_busy, 1);
    chk("R8 unbounded no timeout", u_to, 0);
    q_u.push_back(LIM + 1);
    cyc(0, 1, 0);
    chk("R8 unbounded ends on ready", u_busy, 0);
    chk("R6 stray ready after timeout", e_un, 1);
    cyc(0, 0, 1);
    hs(9);
    chk("R10 clean after timeout", e_to, 0);
    chk("R3 queues drained", q_b.size() + q_u.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule